// File: doc/BRIEF.md
# Interrupt Controller Register Block

This block collects six peripheral interrupt sources into a sticky pending register. It drives a single CPU interrupt line, which is high whenever any pending source is also enabled in the mask register. The block also holds a ten-bit mode register. Software reaches the block through a plain 32-bit word port that carries an address, write data and a per-bit write mask. Only the bits that the mask lets through take effect.

The mode flags and the mask bits are never loaded directly. Each one has a clear command bit and a set command bit, and a write that carries both leaves the bit set. Sources are treated as level or edge inputs, chosen per source by a parameter. The DP source (index 5) is the only pending bit that software can clear, and it does so through a command bit in the mode register. If the source raises it in the same cycle, the source wins. Reads are combinational. Register state changes on the clock edge that accepts a write.

Top module: `intc_regblk`

## Requirements
- R1: After reset the mode, mask and pending registers are zero and `cpu_irq` is low.
- R2: Decoding uses address bits 28:0 only, so bits 31:29 are don't-care. Offset 0x0 is mode, 0x4 is version, 0x8 is pending and 0xC is mask. Any other offset, unaligned ones included, reads as zero and ignores writes.
- R3: A write acts on `bus_wdata & bus_wmask` only. A data bit whose mask bit is 0 behaves as if it were 0.
- R4: A mode write copies masked bits 6:0 into mode bits 6:0.
- R5: Mode flags are init (bit 7), test-bus (bit 8) and memory-register (bit 9). A mode write clears init with bit 7 and sets it with bit 8. It clears test-bus with bit 9 and sets it with bit 10. It clears memory-register with bit 12 and sets it with bit 13. When both bits of a pair are 1, the flag ends set.
- R6: Mask and pending bits share one layout: SP=0, SI=1, AI=2, VI=3, PI=4, DP=5. In a mask write, bit 2i clears mask bit i and bit 2i+1 sets it. When both are 1, the bit ends set.
- R7: A level source sets its pending bit on every clock edge at which it is high. An edge source (a bit set in `SRC_EDGE`, default DP only) sets its pending bit only on a 0-to-1 change. Pending bits stay set until cleared.
- R8: Bit 11 of a mode write clears the DP pending bit. A DP source set in the same cycle overrides that clear.
- R9: `cpu_irq` is high exactly when some source is both pending and unmasked. It follows the registers with no extra cycle of delay.
- R10: Writes to the version and pending offsets change nothing. The version offset always reads the `VERSION` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 6 | Peripheral interrupt requests, SP at bit 0 to DP at bit 5 |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
A write or a source request that is present at a rising edge shows up in the registers at that same edge. From then on it is visible on `bus_rdata` and `cpu_irq` without a further cycle. A read result depends only on the address and the current state, so it is valid in the cycle the address is applied.

The bench drives inputs on the falling edge. It compares both outputs against its reference model 1 ns after each rising edge. Directed reads are checked 1 ns after their address is driven, well ahead of the next rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC      = 6;
  localparam int MODE_W    = 10;
  localparam int MODE_LOW  = 7;
  localparam int MB_INIT   = 7;
  localparam int MB_TBUS   = 8;
  localparam int MB_MREG   = 9;
  localparam int MC_CLR_INIT = 7;
  localparam int MC_SET_INIT = 8;
  localparam int MC_CLR_TBUS = 9;
  localparam int MC_SET_TBUS = 10;
  localparam int MC_CLR_DP   = 11;
  localparam int MC_CLR_MREG = 12;
  localparam int MC_SET_MREG = 13;
  localparam int MC_W        = 14;
  localparam int MK_W        = 2 * NSRC;
  localparam int SRC_DP      = 5;

  typedef enum logic [1:0] {
    RS_MODE = 2'd0,
    RS_VER  = 2'd1,
    RS_PEND = 2'd2,
    RS_MASK = 2'd3
  } reg_sel_e;

  // clear applies first, then set: set dominates
  function automatic logic pair_apply(input logic cur, input logic clr, input logic set);
    logic r;
    r = cur;
    if (clr) r = 1'b0;
    if (set) r = 1'b1;
    return r;
  endfunction

  function automatic logic [MODE_W-1:0] mode_next(input logic [MODE_W-1:0] cur,
                                                  input logic [MC_W-1:0] mv);
    logic [MODE_W-1:0] n;
    n = cur;
    n[MODE_LOW-1:0] = mv[MODE_LOW-1:0];
    n[MB_INIT] = pair_apply(cur[MB_INIT], mv[MC_CLR_INIT], mv[MC_SET_INIT]);
    n[MB_TBUS] = pair_apply(cur[MB_TBUS], mv[MC_CLR_TBUS], mv[MC_SET_TBUS]);
    n[MB_MREG] = pair_apply(cur[MB_MREG], mv[MC_CLR_MREG], mv[MC_SET_MREG]);
    return n;
  endfunction
endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_pkg::*;
#(
  parameter int              DEC_W = 29,
  parameter logic [DEC_W-1:0] BASE = '0
) (
  input  logic [DEC_W-1:0] addr_lo,
  input  logic             acc_en,
  input  logic             acc_we,
  output logic             hit,
  output reg_sel_e         rsel,
  output logic [3:0]       wr_oh
);
  logic [DEC_W-1:0] off;

  assign off  = addr_lo - BASE;
  assign hit  = (off[DEC_W-1:4] == '0) && (off[1:0] == 2'b00);
  assign rsel = reg_sel_e'(off[3:2]);

  for (genvar k = 0; k < 4; k++) begin : g_wr
    assign wr_oh[k] = acc_en && acc_we && hit && (off[3:2] == 2'(k));
  end
endmodule

// File: rtl/intc_mode_reg.sv
module intc_mode_reg
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MC_W-1:0]   mval,
  output logic [MODE_W-1:0] mode_q,
  output logic              dp_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= mode_next(mode_q, mval);
  end

  assign dp_clr = wr_en && mval[MC_CLR_DP];
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [MK_W-1:0] mval,
  output logic [NSRC-1:0] mask_q
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     mask_q[i] <= 1'b0;
      else if (wr_en) mask_q[i] <= pair_apply(mask_q[i], mval[2*i], mval[2*i+1]);
    end
  end
endmodule

// File: rtl/intc_pend_reg.sv
module intc_pend_reg
  import intc_pkg::*;
#(
  parameter logic [NSRC-1:0] SRC_EDGE = 6'b100000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            dp_clr,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] src_set
);
  logic [NSRC-1:0] clr_vec;

  assign clr_vec = dp_clr ? (NSRC'(1) << SRC_DP) : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (SRC_EDGE[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in[i];
      end
      assign src_set[i] = src_in[i] && !prev_q;
    end else begin : g_level
      assign src_set[i] = src_in[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] && !clr_vec[i]) || src_set[i];
    end
  end
endmodule

// File: rtl/intc_regblk.sv
module intc_regblk
  import intc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               DATA_W   = 32,
  parameter int               DEC_W    = 29,
  parameter logic [DEC_W-1:0] BASE     = '0,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_0102,
  parameter logic [NSRC-1:0]  SRC_EDGE = 6'b100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_wmask,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              cpu_irq
);
  logic [DATA_W-1:0] mval;
  logic              hit;
  reg_sel_e          rsel;
  logic [3:0]        wr_oh;
  logic              wr_mode;
  logic              wr_mask;
  logic              dp_clr;
  logic [MODE_W-1:0] mode_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   src_set;
  logic              unused_bits;

  assign mval    = bus_wdata & bus_wmask;
  assign wr_mode = wr_oh[RS_MODE];
  assign wr_mask = wr_oh[RS_MASK];
  assign unused_bits = ^{bus_addr[ADDR_W-1:DEC_W], mval[DATA_W-1:MC_W], wr_oh[RS_PEND], wr_oh[RS_VER]};

  intc_addr_dec #(.DEC_W(DEC_W), .BASE(BASE)) u_dec (
    .addr_lo (bus_addr[DEC_W-1:0]),
    .acc_en  (bus_sel),
    .acc_we  (bus_we),
    .hit     (hit),
    .rsel    (rsel),
    .wr_oh   (wr_oh)
  );

  intc_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_mode),
    .mval   (mval[MC_W-1:0]),
    .mode_q (mode_q),
    .dp_clr (dp_clr)
  );

  intc_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_mask),
    .mval   (mval[MK_W-1:0]),
    .mask_q (mask_q)
  );

  intc_pend_reg #(.SRC_EDGE(SRC_EDGE)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_in  (src_in),
    .dp_clr  (dp_clr),
    .pend_q  (pend_q),
    .src_set (src_set)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (rsel)
        RS_MODE: bus_rdata = DATA_W'(mode_q);
        RS_VER:  bus_rdata = VERSION;
        RS_PEND: bus_rdata = DATA_W'(pend_q);
        RS_MASK: bus_rdata = DATA_W'(mask_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign cpu_irq = |(pend_q & mask_q);
endmodule

// File: rtl/intc_regblk_chk.sv
module intc_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_wmask,
  input logic        cpu_irq,
  input logic        wr_mode,
  input logic        wr_mask,
  input logic        dp_clr,
  input logic [9:0]  mode_q,
  input logic [5:0]  mask_q,
  input logic [5:0]  pend_q,
  input logic [5:0]  src_set
);
  logic [31:0] mv;
  assign mv = bus_wdata & bus_wmask;

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (mode_q == '0 && mask_q == '0 && pend_q == '0));
  // R3
  wmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !bus_wmask[7] && !bus_wmask[8]) |=> mode_q[7] == $past(mode_q[7]));
  // R5
  init_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_mode && mv[8]) |=> mode_q[7]);
  // R6
  mask_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_mask && mv[1]) |=> mask_q[0]);
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_mode |=> $stable(mode_q));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_mask |=> $stable(mask_q));
  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_clr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R7
  src_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));
  // R8
  dp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (dp_clr && !src_set[5]) |=> !pend_q[5]);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n) (mask_q == '0) |-> !cpu_irq);
endmodule

bind intc_regblk intc_regblk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .bus_wmask (bus_wmask),
  .cpu_irq   (cpu_irq),
  .wr_mode   (wr_mode),
  .wr_mask   (wr_mask),
  .dp_clr    (dp_clr),
  .mode_q    (mode_q),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .src_set   (src_set)
);

// File: tb/sim_intc_regblk.sv
`timescale 1ns/1ps
module sim_intc_regblk;
  localparam logic [31:0] VER  = 32'h0000_0102;
  localparam logic [5:0]  EDGE = 6'b100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_wmask = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  src_in = '0;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  intc_regblk #(.VERSION(VER), .SRC_EDGE(EDGE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wmask(bus_wmask),
    .bus_rdata(bus_rdata), .src_in(src_in), .cpu_irq(cpu_irq)
  );

  // behavioural reference model
  int unsigned m_mode = 0, m_mask = 0, m_pend = 0, m_prev = 0;

  function automatic int unsigned m_read(input logic [31:0] a);
    int unsigned off;
    off = a & 32'h1FFF_FFFF;
    if (off == 0)       return m_mode;
    else if (off == 4)  return VER;
    else if (off == 8)  return m_pend;
    else if (off == 12) return m_mask;
    return 0;
  endfunction

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int unsigned mv, off, rise, setv, clrdp;
    if (!rst_n) begin
      m_mode = 0; m_mask = 0; m_pend = 0; m_prev = 0;
    end else begin
      mv = bus_wdata & bus_wmask;
      off = bus_addr & 32'h1FFF_FFFF;
      clrdp = 0;
      if (bus_sel && bus_we && off == 0) begin
        m_mode = (m_mode & ~32'h7F) | (mv & 32'h7F);
        if (mv & 32'h0080) m_mode &= ~32'h080;
        if (mv & 32'h0100) m_mode |=  32'h080;
        if (mv & 32'h0200) m_mode &= ~32'h100;
        if (mv & 32'h0400) m_mode |=  32'h100;
        if (mv & 32'h1000) m_mode &= ~32'h200;
        if (mv & 32'h2000) m_mode |=  32'h200;
        if (mv & 32'h0800) clrdp = 1;
      end
      if (bus_sel && bus_we && off == 12) begin
        for (int i = 0; i < 6; i++) begin
          if ((mv >> (2*i)) & 1)   m_mask &= ~(1 << i);
          if ((mv >> (2*i+1)) & 1) m_mask |=  (1 << i);
        end
      end
      rise = src_in & ~m_prev;
      setv = (src_in & ~EDGE) | (rise & EDGE);
      if (clrdp) m_pend &= ~32'h20;
      m_pend |= setv;
      m_prev = src_in;
    end
    #1;
    if (rst_n) begin
      check("R9 irq vs model", cpu_irq, ((m_pend & m_mask) != 0));
      check("R2 rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic src(input logic [5:0] v);
    @(negedge clk);
    src_in = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(32'h0, 32'h0, "R1 mode reset");
    rd(32'h8, 32'h0, "R1 pend reset");
    rd(32'hC, 32'h0, "R1 mask reset");
    check("R1 irq reset", cpu_irq, 0);
    rd(32'h4, VER, "R10 version");

    wr(32'h0, 32'h7F, 32'hFFFF_FFFF);
    rd(32'h0, 32'h7F, "R4 low bits");
    wr(32'h0, 32'h100, 32'hFFFF_FFFF);
    rd(32'h0, 32'h080, "R5 set init");
    wr(32'h0, 32'h180, 32'hFFFF_FFFF);
    rd(32'h0, 32'h080, "R5 init set wins");
    wr(32'h0, 32'h080, 32'hFFFF_FFFF);
    rd(32'h0, 32'h000, "R5 clear init");
    wr(32'h0, 32'h2400, 32'hFFFF_FFFF);
    rd(32'h0, 32'h300, "R5 set tbus mreg");
    wr(32'h0, 32'h1200, 32'hFFFF_FFFF);
    rd(32'h0, 32'h000, "R5 clear tbus mreg");
    wr(32'h0, 32'h2103, 32'h0000_0003);
    rd(32'h0, 32'h003, "R3 write mask");

    wr(32'hC, 32'hAAA, 32'hFFFF_FFFF);
    rd(32'hC, 32'h3F, "R6 set all");
    wr(32'hC, 32'h555, 32'hFFFF_FFFF);
    rd(32'hC, 32'h00, "R6 clear all");
    wr(32'hC, 32'h0C0, 32'hFFFF_FFFF);
    rd(32'hC, 32'h08, "R6 VI set wins");
    wr(32'hC, 32'h040, 32'hFFFF_FFFF);
    rd(32'hC, 32'h00, "R6 VI clear");

    wr(32'hE000_000C, 32'h002, 32'hFFFF_FFFF);
    rd(32'hC, 32'h01, "R2 alias high bits");
    wr(32'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(32'h10, 32'h0, "R2 undecoded read");
    rd(32'h6, 32'h0, "R2 unaligned read");
    rd(32'hC, 32'h01, "R2 undecoded write ignored");

    src(6'b000100);
    src(6'b000000);
    rd(32'h8, 32'h04, "R7 level AI");
    check("R9 irq masked off", cpu_irq, 0);
    wr(32'hC, 32'h020, 32'hFFFF_FFFF);
    rd(32'h8, 32'h04, "R7 sticky");
    check("R9 irq on", cpu_irq, 1);
    wr(32'h8, 32'h0, 32'hFFFF_FFFF);
    rd(32'h8, 32'h04, "R10 pend write ignored");
    wr(32'h4, 32'h0, 32'hFFFF_FFFF);
    rd(32'h4, VER, "R10 version write ignored");

    wr(32'hC, 32'h810, 32'hFFFF_FFFF);
    src(6'b100000);
    @(negedge clk);
    rd(32'h8, 32'h24, "R7 edge DP");
    wr(32'h0, 32'h800, 32'hFFFF_FFFF);
    rd(32'h8, 32'h04, "R8 DP clear while held");
    check("R9 irq after DP clear", cpu_irq, 0);
    src(6'b000000);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 32'h0; bus_wdata = 32'h800; bus_wmask = 32'hFFFF_FFFF;
    src_in = 6'b100000;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd(32'h8, 32'h24, "R8 source set wins");
    check("R9 irq DP", cpu_irq, 1);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule